// File: doc/BRIEF.md
# Debug communications mailbox channel

This block is a two-way, single-word mailbox between an external debugger and a processor core. The debugger places a 32-bit word in the receive slot, and the processor picks it up. The processor places a 32-bit word in the transmit slot, and the debugger collects it. Each slot has a full flag. Both flags are shown in a 32-bit status word that either side may read. All other bits of the status word are zero.

Each slot is a two-state machine with the states `SLOT_EMPTY` and `SLOT_FULL`. It has these transitions:

- FILL: `SLOT_EMPTY` to `SLOT_FULL`, on a write by the producing side.
- DRAIN: `SLOT_FULL` to `SLOT_EMPTY`, on a read by the consuming side with no write in the same cycle.
- OVERWRITE: `SLOT_FULL` to `SLOT_FULL`, on a write while the slot is full. The stored word is replaced.
- IDLE: no change, when there is no strobe, or when the consumer reads an empty slot.

When a write and a read hit the same slot in the same cycle, the write wins. The slot stays full and holds the new word. Flag changes appear in the status word on the cycle after the strobe. Reading an empty receive slot returns the stale contents, which carry no meaning.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset both slots are empty, so the status word reads 0.
- R2: A debugger receive write stores the word. From the next cycle, status bit 30 is 1 and `cpu_rx_rdata` shows the word.
- R3: A processor receive read on a full slot, with no debugger write in the same cycle, clears status bit 30 from the next cycle.
- R4: A processor transmit write stores the word. From the next cycle, status bit 29 is 1 and `dbg_tx_rdata` shows the word.
- R5: A debugger transmit read on a full slot, with no processor write in the same cycle, clears status bit 29 from the next cycle.
- R6: A processor transmit write while bit 29 is 1 replaces the stored word, and bit 29 stays 1, with no stall or error.
- R7: A debugger receive write while bit 30 is 1 replaces the stored word, and bit 30 stays 1.
- R8: If a write and a read hit the same slot in the same cycle, the slot ends full and holds the newly written word.
- R9: Every status bit other than 30 and 29, including bit 31, always reads 0.
- R10: A read of an empty slot leaves its flag at 0. A strobe on one slot never changes the other slot's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_rx_wr | input | 1 | Debugger writes the receive slot |
| dbg_rx_wdata | input | 32 | Word written by the debugger |
| dbg_tx_rd | input | 1 | Debugger reads the transmit slot |
| dbg_tx_rdata | output | 32 | Transmit slot contents |
| cpu_rx_rd | input | 1 | Processor reads the receive slot |
| cpu_rx_rdata | output | 32 | Receive slot contents |
| cpu_tx_wr | input | 1 | Processor writes the transmit slot |
| cpu_tx_wdata | input | 32 | Word written by the processor |
| status | output | 32 | Status word: bit 30 is receive full, bit 29 is transmit full, all other bits 0 |

## Verification
The bound checker checks the following on every cycle:

- Each write sets its flag and captures its data on the next cycle.
- Each lone read clears its flag.
- A write beats a read in the same cycle.
- The unused status bits stay zero.
- With no strobe on a slot, its flag does not move.

Only the directed scenarios can show the rest. These are the longer sequences: an overwrite of a full slot followed by a drain that returns only the latest word, reads of empty slots, and the isolation of each slot from strobes on the other. They also show the exact status values after reset and across mixed traffic on both slots.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int MBX_DATA_W  = 32;
    localparam int MBX_STAT_W  = 32;
    localparam int MBX_RX_BIT  = 30;
    localparam int MBX_TX_BIT  = 29;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_t;
endpackage

// File: rtl/mbx_slot.sv
// One-word slot: a producer fills it, a consumer drains it, and a fill beats a drain.
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int W = MBX_DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fill,
    input  logic [W-1:0] fill_data,
    input  logic         drain,
    output logic         full,
    output logic [W-1:0] word
);
    slot_state_t  st_q, st_nx;
    logic [W-1:0] word_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_nx;
    end

    // Transitions: FILL, DRAIN, OVERWRITE, IDLE
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            SLOT_EMPTY: if (fill)           st_nx = SLOT_FULL;   // FILL
            SLOT_FULL:  if (!fill && drain) st_nx = SLOT_EMPTY;  // DRAIN
            default:                        st_nx = SLOT_EMPTY;
        endcase
    end

    // Data register: every fill captures, including an overwrite
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= '0;
        else if (fill) word_q <= fill_data;
    end

    // Outputs
    always_comb begin
        full = (st_q == SLOT_FULL);
        word = word_q;
    end
endmodule

// File: rtl/mbx_status.sv
// Builds the status word from the two flags; every other bit is zero.
module mbx_status #(
    parameter int W      = 32,
    parameter int RX_BIT = 30,
    parameter int TX_BIT = 29
) (
    input  logic         rx_full,
    input  logic         tx_full,
    output logic [W-1:0] word
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == RX_BIT) begin : g_rx
            assign word[b] = rx_full;
        end else if (b == TX_BIT) begin : g_tx
            assign word[b] = tx_full;
        end else begin : g_zero
            assign word[b] = 1'b0;
        end
    end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W = MBX_DATA_W,
    parameter int STAT_W = MBX_STAT_W,
    parameter int RX_BIT = MBX_RX_BIT,
    parameter int TX_BIT = MBX_TX_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_rx_wr,
    input  logic [DATA_W-1:0] dbg_rx_wdata,
    input  logic              dbg_tx_rd,
    output logic [DATA_W-1:0] dbg_tx_rdata,
    input  logic              cpu_rx_rd,
    output logic [DATA_W-1:0] cpu_rx_rdata,
    input  logic              cpu_tx_wr,
    input  logic [DATA_W-1:0] cpu_tx_wdata,
    output logic [STAT_W-1:0] status
);
    localparam int NCH   = 2;
    localparam int CH_RX = 0;
    localparam int CH_TX = 1;

    logic              fill_v  [NCH];
    logic              drain_v [NCH];
    logic [DATA_W-1:0] data_v  [NCH];
    logic              full_v  [NCH];
    logic [DATA_W-1:0] word_v  [NCH];

    // Receive: the debugger produces, the processor consumes.
    // Transmit: the processor produces, the debugger consumes.
    always_comb begin
        fill_v[CH_RX]  = dbg_rx_wr;
        data_v[CH_RX]  = dbg_rx_wdata;
        drain_v[CH_RX] = cpu_rx_rd;
        fill_v[CH_TX]  = cpu_tx_wr;
        data_v[CH_TX]  = cpu_tx_wdata;
        drain_v[CH_TX] = dbg_tx_rd;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_slot
        mbx_slot #(.W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .fill     (fill_v[c]),
            .fill_data(data_v[c]),
            .drain    (drain_v[c]),
            .full     (full_v[c]),
            .word     (word_v[c])
        );
    end

    assign cpu_rx_rdata = word_v[CH_RX];
    assign dbg_tx_rdata = word_v[CH_TX];

    mbx_status #(.W(STAT_W), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_status (
        .rx_full(full_v[CH_RX]),
        .tx_full(full_v[CH_TX]),
        .word   (status)
    );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int DATA_W = 32,
    parameter int STAT_W = 32,
    parameter int RX_BIT = 30,
    parameter int TX_BIT = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_rx_wr,
    input logic [DATA_W-1:0] dbg_rx_wdata,
    input logic              dbg_tx_rd,
    input logic [DATA_W-1:0] dbg_tx_rdata,
    input logic              cpu_rx_rd,
    input logic [DATA_W-1:0] cpu_rx_rdata,
    input logic              cpu_tx_wr,
    input logic [DATA_W-1:0] cpu_tx_wdata,
    input logic [STAT_W-1:0] status
);
    localparam logic [STAT_W-1:0] FLAG_MASK =
        (STAT_W'(1) << RX_BIT) | (STAT_W'(1) << TX_BIT);

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> status == '0);
    assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rx_wr |=> status[RX_BIT] && cpu_rx_rdata == $past(dbg_rx_wdata));
    assert_rx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rx_rd && !dbg_rx_wr |=> !status[RX_BIT]);
    assert_tx_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tx_wr |=> status[TX_BIT] && dbg_tx_rdata == $past(cpu_tx_wdata));
    assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_tx_rd && !cpu_tx_wr |=> !status[TX_BIT]);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rx_wr && cpu_rx_rd) || (cpu_tx_wr && dbg_tx_rd)
        |=> status[RX_BIT] || status[TX_BIT]);
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~FLAG_MASK) == '0);
    assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_rx_wr && !cpu_rx_rd |=> $stable(status[RX_BIT]));
    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_tx_wr && !dbg_tx_rd |=> $stable(status[TX_BIT]));
endmodule

bind dbg_mailbox mbx_checker #(
    .DATA_W(DATA_W), .STAT_W(STAT_W), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .dbg_rx_wr(dbg_rx_wr), .dbg_rx_wdata(dbg_rx_wdata),
    .dbg_tx_rd(dbg_tx_rd), .dbg_tx_rdata(dbg_tx_rdata),
    .cpu_rx_rd(cpu_rx_rd), .cpu_rx_rdata(cpu_rx_rdata),
    .cpu_tx_wr(cpu_tx_wr), .cpu_tx_wdata(cpu_tx_wdata),
    .status(status)
);

// File: tb/sim_dbg_mailbox.sv
`timescale 1ns/1ps
module sim_dbg_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_rx_wr = 1'b0, dbg_tx_rd = 1'b0, cpu_rx_rd = 1'b0, cpu_tx_wr = 1'b0;
    logic [31:0] dbg_rx_wdata = '0, cpu_tx_wdata = '0;
    logic [31:0] dbg_tx_rdata, cpu_rx_rdata, status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dbg_mailbox u0 (
        .clk(clk), .rst_n(rst_n),
        .dbg_rx_wr(dbg_rx_wr), .dbg_rx_wdata(dbg_rx_wdata),
        .dbg_tx_rd(dbg_tx_rd), .dbg_tx_rdata(dbg_tx_rdata),
        .cpu_rx_rd(cpu_rx_rd), .cpu_rx_rdata(cpu_rx_rdata),
        .cpu_tx_wr(cpu_tx_wr), .cpu_tx_wdata(cpu_tx_wdata),
        .status(status)
    );

    // Expected status: bit 30 receive full, bit 29 transmit full, all else 0
    function automatic logic [31:0] stat_of(bit rx, bit tx);
        return (32'(rx) << 30) | (32'(tx) << 29);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: inputs already driven after a falling edge; sample at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        dbg_rx_wr = 0; dbg_tx_rd = 0; cpu_rx_rd = 0; cpu_tx_wr = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", status, 32'h0);
        chk("R9 reset reserved", status & ~stat_of(1, 1), 32'h0);
    endtask

    task automatic t_rx_path();
        dbg_rx_wr = 1; dbg_rx_wdata = 32'hCAFE_0001; step();
        chk("R2 rx full", status, stat_of(1, 0));
        chk("R2 rx data", cpu_rx_rdata, 32'hCAFE_0001);
        cpu_rx_rd = 1; step();
        chk("R3 rx drained", status, stat_of(0, 0));
    endtask

    task automatic t_tx_path();
        cpu_tx_wr = 1; cpu_tx_wdata = 32'h1234_5678; step();
        chk("R4 tx full", status, stat_of(0, 1));
        chk("R4 tx data", dbg_tx_rdata, 32'h1234_5678);
        dbg_tx_rd = 1; step();
        chk("R5 tx drained", status, stat_of(0, 0));
    endtask

    task automatic t_tx_overwrite();
        cpu_tx_wr = 1; cpu_tx_wdata = 32'hAAAA_0001; step();
        cpu_tx_wr = 1; cpu_tx_wdata = 32'hBBBB_0002; step();
        chk("R6 tx still full", status, stat_of(0, 1));
        chk("R6 tx newest word", dbg_tx_rdata, 32'hBBBB_0002);
        dbg_tx_rd = 1; step();
        chk("R6 tx drained once", status, stat_of(0, 0));
    endtask

    task automatic t_rx_overwrite();
        dbg_rx_wr = 1; dbg_rx_wdata = 32'h0F0F_0F0F; step();
        dbg_rx_wr = 1; dbg_rx_wdata = 32'hF0F0_F0F0; step();
        chk("R7 rx still full", status, stat_of(1, 0));
        chk("R7 rx newest word", cpu_rx_rdata, 32'hF0F0_F0F0);
        cpu_rx_rd = 1; step();
        chk("R7 rx drained once", status, stat_of(0, 0));
    endtask

    task automatic t_same_cycle();
        // Empty slot: write and read together
        dbg_rx_wr = 1; dbg_rx_wdata = 32'h5555_AAAA; cpu_rx_rd = 1; step();
        chk("R8 rx set wins empty", status, stat_of(1, 0));
        chk("R8 rx data", cpu_rx_rdata, 32'h5555_AAAA);
        // Full slot: write and read together
        dbg_rx_wr = 1; dbg_rx_wdata = 32'h6666_BBBB; cpu_rx_rd = 1; step();
        chk("R8 rx set wins full", status, stat_of(1, 0));
        chk("R8 rx data full", cpu_rx_rdata, 32'h6666_BBBB);
        cpu_tx_wr = 1; cpu_tx_wdata = 32'h7777_CCCC; step();
        cpu_tx_wr = 1; cpu_tx_wdata = 32'h8888_DDDD; dbg_tx_rd = 1; step();
        chk("R8 tx set wins", status, stat_of(1, 1));
        chk("R8 tx data", dbg_tx_rdata, 32'h8888_DDDD);
        chk("R9 both full reserved", status & ~stat_of(1, 1), 32'h0);
        cpu_rx_rd = 1; dbg_tx_rd = 1; step();
        chk("R3 R5 both drained", status, stat_of(0, 0));
    endtask

    task automatic t_idle_reads();
        cpu_rx_rd = 1; step();
        chk("R10 empty rx read", status, stat_of(0, 0));
        dbg_tx_rd = 1; step();
        chk("R10 empty tx read", status, stat_of(0, 0));
        cpu_tx_wr = 1; cpu_tx_wdata = 32'h0000_0042; step();
        cpu_rx_rd = 1; dbg_rx_wr = 0; step();
        chk("R10 rx read leaves tx", status, stat_of(0, 1));
        dbg_rx_wr = 1; dbg_rx_wdata = 32'h0000_0099; step();
        dbg_tx_rd = 1; step();
        chk("R10 tx read leaves rx", status, stat_of(1, 0));
        repeat (3) step();
        chk("R10 idle holds", status, stat_of(1, 0));
        cpu_rx_rd = 1; step();
    endtask

    function automatic void summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endfunction

    initial begin
        @(negedge clk);
        t_reset();
        t_rx_path();
        t_tx_path();
        t_tx_overwrite();
        t_rx_overwrite();
        t_same_cycle();
        t_idle_reads();
        t_reset();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule